// File: doc/BRIEF.md
# Single-Cycle 16-bit Load/Store Processor Core

This core runs one 32-bit instruction per clock on a 16-bit datapath. Each cycle it presents its program counter on the instruction port and decodes the word that comes back. It reads two registers, computes a result and writes that result back on the same clock edge that advances the program counter. The program counter counts whole instruction words. The instruction and data stores sit outside the core. The instruction port and the data read path are combinational. A data write happens at the rising edge of the cycle that asserts the write strobe.

Besides the usual arithmetic, logic, shift, compare and branch operations, the core contains a multiply unit. The multiply unit keeps the 32-bit product of two registers in a pair of 16-bit result registers, which are read back through dedicated move instructions. An add-and-store instruction writes a register-plus-immediate sum directly to memory, at an address taken from a second register. It writes no register.

Top module: `sc16_core`

## Requirements
- R1: With `rst` high at a rising edge, the program counter becomes 0 and both multiply result registers (high half and low half) become 0.
- R2: There are 32 registers of 16 bits. Register 0 reads as 0 and is never changed by any write. A write to any other register is visible to the next instruction.
- R3: R-type (opcode 0x00) add (funct 0x20), sub (0x22), and (0x24) and or (0x25) write rd with rs op rt, modulo 2^16.
- R4: slt (R-type funct 0x2A) writes 1 to rd when rs is less than rt as signed 16-bit values, and 0 otherwise.
- R5: sll (R-type funct 0x00) writes rd with rs shifted left by the 5-bit shamt field, filling with zeros.
- R6: addi (opcode 0x08) writes register B with register A plus the sign-extended 16-bit immediate.
- R7: mult (R-type funct 0x18) stores the unsigned 32-bit product of rs and rt: bits 31..16 go to the high register and bits 15..0 go to the low register. No other instruction changes them.
- R8: mfhi (funct 0x10) copies the high register to rd, and mflo (funct 0x12) copies the low register to rd.
- R9: lw (opcode 0x23) drives `dmem_addr` with register A plus the sign-extended immediate, and writes the returned `dmem_rdata` into register B in the same cycle.
- R10: sw (opcode 0x2B) asserts `dmem_we` with address register B plus the sign-extended immediate and data register A. `dmem_we` is high only for sw and adds.
- R11: adds (opcode 0x1C) asserts `dmem_we` with address register B and data register A plus the sign-extended immediate, and writes no register.
- R12: beq (opcode 0x04, A equals B) and blez (opcode 0x06, A at most 0 as signed) load PC+1+sign-extended immediate when taken and PC+1 when not. Every other non-jump instruction also advances to PC+1.
- R13: j (opcode 0x02) loads the PC from the low 16 bits of the 26-bit target field.
- R14: Fields are: opcode [31:26]; A/rs [25:21]; B/rt [20:16]; rd [15:11]; shamt [10:6]; funct [5:0]; immediate [15:0]; target [25:0]. An undefined opcode or R-type funct changes no register, no memory and no multiply result, and advances to PC+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 16 | Word address of the current instruction |
| imem_data | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | 16 | Data word address for loads and stores |
| dmem_wdata | output | 16 | Store data |
| dmem_we | output | 1 | Store strobe; write at the rising edge |
| dmem_rdata | input | 16 | Load data at `dmem_addr`, combinational |

## Verification
The hardest cases to reach are those whose effect lives only in internal state: the reset value of the multiply result registers, writes aimed at register 0, and instructions with undefined codes. The ports never show any of these directly. The stimulus program therefore reads that state out with mfhi, mflo and stores right after reset and right after each such instruction. It also runs a counted loop of loads and add-and-stores, takes and skips branches on negative, zero and positive values, and runs a backward branch, so that every outcome reaches the data port.

// File: rtl/sc16_pkg.sv
package sc16_pkg;

    typedef enum logic [5:0] {
        OP_RTYPE = 6'h00,
        OP_J     = 6'h02,
        OP_BEQ   = 6'h04,
        OP_BLEZ  = 6'h06,
        OP_ADDI  = 6'h08,
        OP_ADDS  = 6'h1C,
        OP_LW    = 6'h23,
        OP_SW    = 6'h2B
    } opcode_e;

    typedef enum logic [5:0] {
        FN_SLL  = 6'h00,
        FN_MFHI = 6'h10,
        FN_MFLO = 6'h12,
        FN_MULT = 6'h18,
        FN_ADD  = 6'h20,
        FN_SUB  = 6'h22,
        FN_AND  = 6'h24,
        FN_OR   = 6'h25,
        FN_SLT  = 6'h2A
    } funct_e;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_SLL
    } alu_op_e;

    typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_HI, WB_LO} wb_sel_e;

    typedef enum logic [1:0] {FL_SEQ, FL_EQ, FL_LEZ, FL_JUMP} flow_e;

    typedef struct packed {
        alu_op_e alu_op;
        logic    use_imm;
        logic    reg_we;
        logic    dst_is_rd;
        wb_sel_e wb_sel;
        logic    mem_we;
        logic    store_sum;
        logic    mul_en;
        flow_e   flow;
    } ctrl_t;

endpackage

// File: rtl/sc16_decode.sv
module sc16_decode
    import sc16_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl.alu_op    = ALU_ADD;
        ctrl.use_imm   = 1'b0;
        ctrl.reg_we    = 1'b0;
        ctrl.dst_is_rd = 1'b0;
        ctrl.wb_sel    = WB_ALU;
        ctrl.mem_we    = 1'b0;
        ctrl.store_sum = 1'b0;
        ctrl.mul_en    = 1'b0;
        ctrl.flow      = FL_SEQ;
        case (opcode)
            OP_RTYPE: begin
                ctrl.dst_is_rd = 1'b1;
                case (funct)
                    FN_ADD:  ctrl.reg_we = 1'b1;
                    FN_SUB:  begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SUB; end
                    FN_AND:  begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_AND; end
                    FN_OR:   begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_OR;  end
                    FN_SLT:  begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SLT; end
                    FN_SLL:  begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SLL; end
                    FN_MULT: ctrl.mul_en = 1'b1;
                    FN_MFHI: begin ctrl.reg_we = 1'b1; ctrl.wb_sel = WB_HI; end
                    FN_MFLO: begin ctrl.reg_we = 1'b1; ctrl.wb_sel = WB_LO; end
                    default: ;
                endcase
            end
            OP_ADDI: begin ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; end
            OP_LW: begin
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.wb_sel  = WB_MEM;
            end
            OP_SW:   ctrl.mem_we = 1'b1;
            OP_ADDS: begin
                ctrl.mem_we    = 1'b1;
                ctrl.store_sum = 1'b1;
                ctrl.use_imm   = 1'b1;
            end
            OP_BEQ:  ctrl.flow = FL_EQ;
            OP_BLEZ: ctrl.flow = FL_LEZ;
            OP_J:    ctrl.flow = FL_JUMP;
            default: ;
        endcase
    end

endmodule

// File: rtl/sc16_alu.sv
module sc16_alu
    import sc16_pkg::*;
#(
    parameter int W  = 16,
    parameter int SW = 5
) (
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic [SW-1:0] shamt,
    input  alu_op_e       op,
    output logic [W-1:0]  y
);

    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = ($signed(a) < $signed(b)) ? W'(1) : '0;
            ALU_SLL: y = a << shamt;
            default: y = a + b;
        endcase
    end

endmodule

// File: rtl/sc16_regfile.sv
module sc16_regfile #(
    parameter int W  = 16,
    parameter int N  = 32,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata
);

    logic [N-1:0][W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we && waddr != '0) regs_d[waddr] = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    assign rdata_a = (raddr_a == '0) ? '0 : regs_q[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : regs_q[raddr_b];

    // R2: a write to a nonzero register is what the next read of it returns
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        (we && waddr != '0) |=> regs_q[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/sc16_mul.sv
module sc16_mul #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo
);

    typedef struct packed {
        logic [W-1:0] hi;
        logic [W-1:0] lo;
    } mul_state_t;

    mul_state_t st_d, st_q;
    logic [2*W-1:0] prod;

    always_comb begin
        prod = (2*W)'(a) * (2*W)'(b);
        st_d = st_q;
        if (en) begin
            st_d.hi = prod[2*W-1:W];
            st_d.lo = prod[W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign hi = st_q.hi;
    assign lo = st_q.lo;

    // R7: the result pair holds the unsigned product after a multiply
    a_r7_product: assert property (@(posedge clk) disable iff (rst)
        en |=> {hi, lo} == (2*W)'($past(a)) * (2*W)'($past(b)));

    // R7: without a multiply, the result pair keeps its value
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable({hi, lo}));

endmodule

// File: rtl/sc16_core.sv
// Single-cycle 16-bit core, 32-bit instruction words.
// Encoding:
//   [31:26] opcode   [25:21] A (rs)   [20:16] B (rt)
//   R-type: [15:11] rd  [10:6] shamt  [5:0] funct
//   I-type: [15:0] immediate, sign-extended
//   J-type: [25:0] target, low PC bits used
// Opcodes: 00 R-type, 02 j, 04 beq, 06 blez, 08 addi, 1C adds, 23 lw, 2B sw
// Functs:  00 sll, 10 mfhi, 12 mflo, 18 mult, 20 add, 22 sub, 24 and,
//          25 or, 2A slt
// addi: B = A + imm         lw: B = mem[A + imm]
// sw:   mem[B + imm] = A    adds: mem[B] = A + imm
// beq/blez taken: PC = PC + 1 + imm
// Undefined codes behave as no-operation.
module sc16_core
    import sc16_pkg::*;
#(
    parameter int XLEN = 16,
    parameter int ILEN = 32,
    parameter int PC_W = 16,
    parameter int NREG = 32
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PC_W-1:0] imem_addr,
    input  logic [ILEN-1:0] imem_data,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata
);

    localparam int RAW   = $clog2(NREG);
    localparam int IMM_W = 16;
    localparam int TGT_W = 26;

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } core_state_t;

    core_state_t st_d, st_q;
    ctrl_t ctrl;

    logic [RAW-1:0]   f_a, f_b, f_rd;
    logic [4:0]       f_shamt;
    logic [IMM_W-1:0] f_imm;
    logic [TGT_W-1:0] f_tgt;
    logic [XLEN-1:0]  imm_sx, a_val, b_val, alu_b, alu_y, wb_data, hi, lo;
    logic [PC_W-1:0]  seq_pc, br_pc, jump_pc;
    logic             taken;

    assign f_a     = imem_data[25:21];
    assign f_b     = imem_data[20:16];
    assign f_rd    = imem_data[15:11];
    assign f_shamt = imem_data[10:6];
    assign f_imm   = imem_data[15:0];
    assign f_tgt   = imem_data[25:0];
    assign imm_sx  = XLEN'($signed(f_imm));

    sc16_decode u_dec (
        .opcode (imem_data[31:26]),
        .funct  (imem_data[5:0]),
        .ctrl   (ctrl)
    );

    sc16_regfile #(.W(XLEN), .N(NREG)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .raddr_a (f_a),
        .raddr_b (f_b),
        .rdata_a (a_val),
        .rdata_b (b_val),
        .we      (ctrl.reg_we),
        .waddr   (ctrl.dst_is_rd ? f_rd : f_b),
        .wdata   (wb_data)
    );

    assign alu_b = ctrl.use_imm ? imm_sx : b_val;

    sc16_alu #(.W(XLEN), .SW(5)) u_alu (
        .a     (a_val),
        .b     (alu_b),
        .shamt (f_shamt),
        .op    (ctrl.alu_op),
        .y     (alu_y)
    );

    sc16_mul #(.W(XLEN)) u_mul (
        .clk (clk),
        .rst (rst),
        .en  (ctrl.mul_en),
        .a   (a_val),
        .b   (b_val),
        .hi  (hi),
        .lo  (lo)
    );

    always_comb begin
        case (ctrl.wb_sel)
            WB_MEM:  wb_data = dmem_rdata;
            WB_HI:   wb_data = hi;
            WB_LO:   wb_data = lo;
            default: wb_data = alu_y;
        endcase
    end

    // data port
    assign dmem_we    = ctrl.mem_we;
    assign dmem_wdata = ctrl.store_sum ? alu_y : a_val;
    always_comb begin
        if (ctrl.store_sum)   dmem_addr = b_val;
        else if (ctrl.mem_we) dmem_addr = b_val + imm_sx;
        else                  dmem_addr = alu_y;
    end

    // next program counter
    assign seq_pc  = st_q.pc + PC_W'(1);
    assign br_pc   = seq_pc + PC_W'($signed(f_imm));
    assign jump_pc = PC_W'(f_tgt);

    always_comb begin
        case (ctrl.flow)
            FL_EQ:   taken = (a_val == b_val);
            FL_LEZ:  taken = ($signed(a_val) <= 0);
            default: taken = 1'b0;
        endcase
        st_d = st_q;
        if (ctrl.flow == FL_JUMP) st_d.pc = jump_pc;
        else if (taken)           st_d.pc = br_pc;
        else                      st_d.pc = seq_pc;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign imem_addr = st_q.pc;

    // R13: a jump lands on the low bits of its target field
    a_r13_jump_target: assert property (@(posedge clk) disable iff (rst)
        (imem_data[31:26] == OP_J) |=> imem_addr == $past(PC_W'(imem_data[25:0])));

    // R12: instructions other than branches and jumps step by one word
    a_r12_sequential: assert property (@(posedge clk) disable iff (rst)
        !(imem_data[31:26] inside {OP_J, OP_BEQ, OP_BLEZ})
        |=> imem_addr == $past(imem_addr) + PC_W'(1));

    // R10: the store strobe comes only from sw or adds
    a_r10_store_only: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (imem_data[31:26] == OP_SW || imem_data[31:26] == OP_ADDS));

endmodule

// File: tb/sim_sc16_core.sv
`timescale 1ns/1ps
module sim_sc16_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] imem_addr;
    logic [31:0] imem_data;
    logic [15:0] dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] im [256];
    logic [15:0] dm [256];
    logic [15:0] mm [256];
    logic [15:0] mr [32];
    logic [15:0] mhi, mlo, m_pc;
    int          errors = 0;
    int          checks = 0;
    int          n = 0;
    string       prev_tag = "R1";

    always #10 clk = ~clk;

    assign imem_data  = im[imem_addr[7:0]];
    assign dmem_rdata = dm[dmem_addr[7:0]];

    sc16_core u0 (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input int a, input int b,
                                          input int d, input int sh);
        return {6'h00, 5'(a), 5'(b), 5'(d), 5'(sh), fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int a, input int b,
                                          input int imm);
        return {op, 5'(a), 5'(b), 16'(imm)};
    endfunction

    task automatic emit(input logic [31:0] w);
        im[n] = w;
        n++;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // one instruction of the behavioural model, compared with the ports
    task automatic step();
        logic [31:0] ins;
        logic [15:0] a, b, sx, npc, wv, ea, ed;
        logic [31:0] p;
        logic        wen, we, rd_chk;
        int          wi;
        string       tag;
        ins = im[m_pc[7:0]];
        a   = mr[ins[25:21]];
        b   = mr[ins[20:16]];
        sx  = ins[15:0];
        npc = m_pc + 16'd1;
        wen = 1'b0; we = 1'b0; rd_chk = 1'b0;
        wi = 0; wv = '0; ea = '0; ed = '0;
        tag = "R14 undefined";
        case (ins[31:26])
            6'h00: begin
                wi = ins[15:11];
                case (ins[5:0])
                    6'h20: begin wen = 1; wv = a + b; tag = "R3 add"; end
                    6'h22: begin wen = 1; wv = a - b; tag = "R3 sub"; end
                    6'h24: begin wen = 1; wv = a & b; tag = "R3 and"; end
                    6'h25: begin wen = 1; wv = a | b; tag = "R3 or"; end
                    6'h2A: begin wen = 1; wv = ($signed(a) < $signed(b)) ? 16'd1 : 16'd0; tag = "R4 slt"; end
                    6'h00: begin wen = 1; wv = a << ins[10:6]; tag = "R5 sll"; end
                    6'h18: begin p = {16'h0, a} * {16'h0, b}; mhi = p[31:16]; mlo = p[15:0]; tag = "R7 mult"; end
                    6'h10: begin wen = 1; wv = mhi; tag = "R8 mfhi"; end
                    6'h12: begin wen = 1; wv = mlo; tag = "R8 mflo"; end
                    default: ;
                endcase
            end
            6'h08: begin wen = 1; wi = ins[20:16]; wv = a + sx; tag = "R6 addi"; end
            6'h23: begin
                ea = a + sx; rd_chk = 1; wen = 1; wi = ins[20:16];
                wv = mm[ea[7:0]]; tag = "R9 lw";
            end
            6'h2B: begin we = 1; ea = b + sx; ed = a; tag = "R10 sw"; end
            6'h1C: begin we = 1; ea = b; ed = a + sx; tag = "R11 adds"; end
            6'h04: begin if (a == b) npc = m_pc + 16'd1 + sx; tag = "R12 beq"; end
            6'h06: begin if ($signed(a) <= 0) npc = m_pc + 16'd1 + sx; tag = "R12 blez"; end
            6'h02: begin npc = ins[15:0]; tag = "R13 j"; end
            default: ;
        endcase
        chk({prev_tag, " pc"}, imem_addr, m_pc);
        chk({tag, " R10 we"}, dmem_we, we);
        if (we || rd_chk) chk({tag, " addr"}, dmem_addr, ea);
        if (we) chk({tag, " data"}, dmem_wdata, ed);
        if (dmem_we) dm[dmem_addr[7:0]] = dmem_wdata;
        if (we) mm[ea[7:0]] = ed;
        if (wen && wi != 0) mr[wi] = wv;
        m_pc = npc;
        prev_tag = (ins[31:26] == 6'h02) ? "R13" : "R12";
    endtask

    initial begin
        int lp, bk;
        for (int i = 0; i < 256; i++) begin
            im[i] = '0; dm[i] = '0; mm[i] = '0;
        end
        for (int i = 0; i < 5; i++) begin
            dm[16 + i] = 16'(100 + 3 * i);
            mm[16 + i] = 16'(100 + 3 * i);
        end
        dm[8'h30] = 16'hDEAD; mm[8'h30] = 16'hDEAD;
        dm[8'h31] = 16'hDEAD; mm[8'h31] = 16'hDEAD;

        emit(enc_r(6'h10, 0, 0, 25, 0));        // mfhi r25 (reset value)
        emit(enc_r(6'h12, 0, 0, 26, 0));        // mflo r26
        emit(enc_i(6'h2B, 25, 0, 16'h30));
        emit(enc_i(6'h2B, 26, 0, 16'h31));
        emit(enc_i(6'h08, 0, 1, 5));            // r1 = 5
        emit(enc_i(6'h08, 0, 2, 16'hFFFD));     // r2 = -3
        emit(enc_r(6'h20, 1, 2, 3, 0));
        emit(enc_r(6'h22, 2, 1, 4, 0));
        emit(enc_r(6'h24, 1, 2, 5, 0));
        emit(enc_r(6'h25, 1, 2, 6, 0));
        emit(enc_r(6'h2A, 2, 1, 7, 0));
        emit(enc_r(6'h2A, 1, 2, 8, 0));
        emit(enc_r(6'h00, 1, 0, 9, 4));
        emit(enc_i(6'h08, 0, 11, 16'hFFFF));
        emit(enc_r(6'h18, 11, 11, 0, 0));
        emit(enc_r(6'h10, 0, 0, 12, 0));
        emit(enc_r(6'h12, 0, 0, 13, 0));
        emit(enc_i(6'h08, 0, 0, 7));            // write to r0
        emit(enc_r(6'h20, 1, 1, 0, 0));         // write to r0
        emit({6'h3F, 5'd1, 5'd1, 16'h1234});    // undefined opcode
        emit(enc_r(6'h3F, 2, 2, 1, 0));         // undefined funct
        emit(enc_i(6'h08, 0, 20, 16'h40));
        emit(enc_i(6'h2B, 3, 20, 0));
        emit(enc_i(6'h2B, 4, 20, 1));
        emit(enc_i(6'h2B, 7, 20, 2));
        emit(enc_i(6'h2B, 8, 20, 3));
        emit(enc_i(6'h2B, 9, 20, 4));
        emit(enc_i(6'h2B, 12, 20, 5));
        emit(enc_i(6'h2B, 13, 20, 6));
        emit(enc_i(6'h2B, 0, 20, 7));
        emit(enc_i(6'h2B, 5, 20, 8));
        emit(enc_i(6'h2B, 6, 20, 9));
        emit(enc_i(6'h2B, 1, 20, 12));
        emit(enc_i(6'h08, 0, 14, 16'h10));
        emit(enc_i(6'h08, 0, 15, 0));
        emit(enc_i(6'h08, 0, 16, 5));
        lp = n;
        emit(enc_i(6'h04, 15, 16, 6));          // exit after five passes
        emit(enc_r(6'h20, 14, 15, 17, 0));
        emit(enc_i(6'h23, 17, 18, 0));
        emit(enc_i(6'h1C, 18, 17, 10));
        emit(enc_i(6'h08, 15, 15, 1));
        emit({6'h02, 26'(lp)});
        emit(enc_i(6'h08, 0, 21, 1));           // skipped
        emit(enc_i(6'h06, 2, 0, 1));            // blez negative: taken
        emit(enc_i(6'h08, 0, 22, 16'h55));
        emit(enc_i(6'h06, 1, 0, 5));            // blez positive: not taken
        emit(enc_i(6'h06, 0, 0, 1));            // blez zero: taken
        emit(enc_i(6'h08, 0, 22, 16'h66));
        emit(enc_i(6'h2B, 22, 20, 10));
        emit(enc_r(6'h18, 1, 2, 0, 0));
        emit(enc_r(6'h10, 0, 0, 24, 0));
        emit(enc_r(6'h12, 0, 0, 27, 0));
        emit(enc_i(6'h2B, 24, 20, 11));
        emit(enc_i(6'h2B, 27, 20, 13));
        emit(enc_i(6'h08, 0, 28, 2));
        bk = n;
        emit(enc_i(6'h08, 28, 28, 16'hFFFF));
        emit(enc_i(6'h04, 28, 0, 1));
        emit(enc_i(6'h04, 0, 0, 16'(bk - (n + 1))));  // backward branch
        emit(enc_i(6'h2B, 28, 20, 14));
        emit({6'h02, 26'(n)});                   // halt

        for (int i = 0; i < 32; i++) mr[i] = '0;
        mhi = '0; mlo = '0; m_pc = '0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset pc", imem_addr, 0);
        rst = 1'b0;
        for (int c = 0; c < 170; c++) begin
            step();
            @(negedge clk);
        end

        chk("R1 hi reset", dm[8'h30], 16'h0000);
        chk("R1 lo reset", dm[8'h31], 16'h0000);
        chk("R3 add", dm[8'h40], 16'h0002);
        chk("R3 sub", dm[8'h41], 16'hFFF8);
        chk("R4 slt signed true", dm[8'h42], 16'h0001);
        chk("R4 slt signed false", dm[8'h43], 16'h0000);
        chk("R5 sll", dm[8'h44], 16'h0050);
        chk("R7 R8 hi", dm[8'h45], 16'hFFFE);
        chk("R7 R8 lo", dm[8'h46], 16'h0001);
        chk("R2 r0 stays zero", dm[8'h47], 16'h0000);
        chk("R3 and", dm[8'h48], 16'h0005);
        chk("R3 or", dm[8'h49], 16'hFFFD);
        chk("R12 skipped writes", dm[8'h4A], 16'h0000);
        chk("R7 hi mixed", dm[8'h4B], 16'h0004);
        chk("R14 undefined no-op", dm[8'h4C], 16'h0005);
        chk("R7 lo mixed", dm[8'h4D], 16'hFFF1);
        chk("R12 backward loop", dm[8'h4E], 16'h0000);
        for (int i = 0; i < 5; i++)
            chk("R9 R11 array", dm[16 + i], 16'(110 + 3 * i));
        chk("R13 halt", imem_addr, 16'(n - 1));
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

endmodule